// File: doc/BRIEF.md
# Zero-Run Vertical Sync Detector

This block watches a digitized composite video stream, one 8-bit sample per clock at the sample rate. After clamping, the sync tip of the signal converts to the code zero, and no other part of the waveform reaches it. The block counts consecutive zero samples. A long run marks a vertical sync interval. A short run is a horizontal sync pulse and is rejected.

The run counter is 7 bits wide and is built as two stages. The lower 4 bits count every zero sample. The upper 3 bits advance only when a registered carry says that the lower stage has just wrapped. The flag `detect_o` is decoded directly from the registered count. It is high when the count reads all ones, which happens after 127 zeros in a row. A line sync run of about 35 samples therefore never sets the flag. A field sync pulse of about 238 samples sets it.

Top module: `vsync_run_detector`

## Requirements
- R1: A sample with any bit set (value not 0x00) clears the whole run count on that clock edge. The flag then needs 127 new consecutive zero samples before it can rise again.
- R2: Each zero sample (value 0x00) adds one to the run count. `detect_o` is high in the cycle after the 127th consecutive zero has been clocked in, which is the cycle in which the 128th sample sits on the bus.
- R3: `detect_o` stays low while fewer than 127 consecutive zeros have been clocked in. A 35-sample run followed by a nonzero sample never raises it.
- R4: If the sample clocked in while `detect_o` is high is zero, the count wraps to 0 and `detect_o` falls. In an unbroken run of zeros the flag is high for one cycle in every 128, so a 238-sample run gives one pulse and a 256-sample run gives two.
- R5: `detect_o` depends only on registered state. A change on `sample_i` within a cycle does not change it before the next clock edge.
- R6: While `rst` is high at a clock edge, both counter stages and the carry register clear. After reset `detect_o` is low, and 127 zeros are needed before it rises.
- R7: A nonzero sample that arrives while the lower stage holds 15 and the carry is pending still clears both stages. The upper stage does not keep the pending increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | SAMPLE_W (8) | Digitized video sample, with 0x00 as the sync level |
| detect_o | output | 1 | Vertical sync detected: the zero-run count equals 127 |

## Verification
A wrong count or a stuck carry does not show at once. It shows only as a detect pulse in the wrong cycle, and only once the run reaches the length where the pulse should appear, which can be up to 128 samples later. An upper stage that keeps counting across a nonzero sample shows as a pulse after a broken run whose pieces add up to 127. A carry that fires at the wrong low-stage value shifts the pulse away from the 128th sample. For these reasons the stimulus uses split runs whose parts add up to exactly 127, a break placed on the lower-stage wrap, and long runs that must give exactly one pulse or exactly two.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

    // Default geometry of the zero-run detector
    parameter int unsigned VSD_SAMPLE_W = 8;
    parameter int unsigned VSD_LO_W     = 4;
    parameter int unsigned VSD_HI_W     = 3;

endpackage

// File: rtl/vsd_zero_det.sv
module vsd_zero_det #(
    parameter int unsigned SAMPLE_W = 8
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic                zero_o
);

    always_comb begin
        zero_o = (sample_i == '0);
    end

endmodule

// File: rtl/vsd_low_stage.sv
module vsd_low_stage #(
    parameter int unsigned LO_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            zero_i,
    output logic [LO_W-1:0] lo_o,
    output logic            carry_o
);

    // The low stage reads one below all ones on the clock edge just before it wraps
    localparam logic [LO_W-1:0] LO_PRE = LO_W'((1 << LO_W) - 2);

    typedef struct packed {
        logic [LO_W-1:0] lo;
        logic            carry;
    } lo_state_t;

    lo_state_t st_d, st_q;

    always_comb begin
        st_d = '0;
        if (zero_i) begin
            st_d.lo    = st_q.lo + 1'b1;
            // The carry is high exactly while the low stage holds all ones
            st_d.carry = (st_q.lo == LO_PRE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lo_o    = st_q.lo;
    assign carry_o = st_q.carry;

endmodule

// File: rtl/vsd_high_stage.sv
module vsd_high_stage #(
    parameter int unsigned HI_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            zero_i,
    input  logic            carry_i,
    output logic [HI_W-1:0] hi_o
);

    typedef struct packed {
        logic [HI_W-1:0] hi;
    } hi_state_t;

    hi_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!zero_i) begin
            st_d.hi = '0;
        end else if (carry_i) begin
            st_d.hi = st_q.hi + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_o = st_q.hi;

endmodule

// File: rtl/vsync_run_detector.sv
module vsync_run_detector
    import vsd_pkg::*;
#(
    parameter int unsigned SAMPLE_W = VSD_SAMPLE_W,
    parameter int unsigned LO_W     = VSD_LO_W,
    parameter int unsigned HI_W     = VSD_HI_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic                detect_o
);

    localparam int unsigned CNT_W = LO_W + HI_W;

    logic            zero_w;
    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;
    logic            carry_q;
    logic [CNT_W-1:0] run_q;

    vsd_zero_det #(.SAMPLE_W(SAMPLE_W)) u_zero (
        .sample_i (sample_i),
        .zero_o   (zero_w)
    );

    vsd_low_stage #(.LO_W(LO_W)) u_low (
        .clk     (clk),
        .rst     (rst),
        .zero_i  (zero_w),
        .lo_o    (lo_q),
        .carry_o (carry_q)
    );

    vsd_high_stage #(.HI_W(HI_W)) u_high (
        .clk     (clk),
        .rst     (rst),
        .zero_i  (zero_w),
        .carry_i (carry_q),
        .hi_o    (hi_q)
    );

    assign run_q    = {hi_q, lo_q};
    // The flag decodes the registered count only, never the live sample
    assign detect_o = &run_q;

endmodule

// File: rtl/vsd_checker.sv
module vsd_checker #(
    parameter int unsigned SAMPLE_W = 8,
    parameter int unsigned LO_W     = 4,
    parameter int unsigned HI_W     = 3
) (
    input logic                clk,
    input logic                rst,
    input logic [SAMPLE_W-1:0] sample,
    input logic                detect,
    input logic [LO_W-1:0]     lo,
    input logic [HI_W-1:0]     hi,
    input logic                carry
);

    localparam int unsigned    CNT_W  = LO_W + HI_W;
    localparam logic [LO_W-1:0] LO_TOP = '1;

    // R1: a nonzero sample empties both stages and the carry
    p_clear_r1: assert property (@(posedge clk) disable iff (rst)
        (sample != '0) |=> (lo == '0 && hi == '0 && !carry));

    // R2: a zero sample advances the joined count by one, with wrap
    p_advance_r2: assert property (@(posedge clk) disable iff (rst)
        (sample == '0) |=> ({hi, lo} == CNT_W'($past({hi, lo}) + 1'b1)));

    // R4: a detect cycle followed by a zero sample ends the pulse
    p_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        (detect && sample == '0) |=> !detect);

    // R7: the carry register tracks the low stage sitting at all ones
    p_carry_r7: assert property (@(posedge clk) disable iff (rst)
        carry == (lo == LO_TOP));

    // R6: reset leaves the flag low and both stages empty
    p_reset_r6: assert property (@(posedge clk)
        rst |=> (!detect && lo == '0 && hi == '0 && !carry));

endmodule

bind vsync_run_detector vsd_checker #(
    .SAMPLE_W (SAMPLE_W),
    .LO_W     (LO_W),
    .HI_W     (HI_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .sample (sample_i),
    .detect (detect_o),
    .lo     (lo_q),
    .hi     (hi_q),
    .carry  (carry_q)
);

// File: tb/vsync_run_detector_test.sv
module vsync_run_detector_test;

    localparam int NSEG = 14;

    // Segment table: sample value and number of clocks it is held
    localparam logic [7:0] SEG_VAL [NSEG] = '{
        8'h00, 8'h10,          // R3: line-sync length run, then break
        8'h00, 8'h01,          // R3: 92 more zeros, no carry-over to 127
        8'h00, 8'h80,          // R1: long run broken by one nonzero sample
        8'h00, 8'h7F,          // R1: 27 zeros would total 127 without the clear
        8'h00, 8'hFF,          // R7: break lands while the carry is pending
        8'h00, 8'h20,          // R2 R4: field-sync length run, one pulse
        8'h00, 8'h40           // R4: 256 zeros, two pulses
    };
    localparam int SEG_LEN [NSEG] = '{
        35, 1, 92, 1, 100, 1, 27, 1, 15, 1, 238, 1, 256, 1
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] sample_i = 8'h00;
    logic       detect_o;

    int checks = 0;
    int fails  = 0;
    int cnt    = 0;
    int pulses = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    vsync_run_detector uut (
        .clk      (clk),
        .rst      (rst),
        .sample_i (sample_i),
        .detect_o (detect_o)
    );

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: detect_o=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one sample from a negedge, clock it, check at the next negedge
    task automatic cycle(input logic [7:0] v, input logic r, input string req);
        sample_i = v;
        rst      = r;
        @(posedge clk);
        if (r)              cnt = 0;
        else if (v == 8'h00) cnt = (cnt + 1) % 128;
        else                cnt = 0;
        @(negedge clk);
        if (cnt == 127) pulses++;
        check(detect_o, (cnt == 127), req);
    endtask

    initial begin
        @(negedge clk);
        cycle(8'h00, 1'b1, "R6");
        cycle(8'h00, 1'b1, "R6");
        check(detect_o, 1'b0, "R6");

        // Table walk
        for (int s = 0; s < NSEG; s++) begin
            for (int k = 0; k < SEG_LEN[s]; k++) begin
                cycle(SEG_VAL[s], 1'b0, (cnt == 126 && SEG_VAL[s] == 8'h00) ? "R2" : "R3");
            end
        end
        check(logic'(pulses == 3), 1'b1, "R4");

        // R6: reset in the middle of a run
        for (int k = 0; k < 60; k++) cycle(8'h00, 1'b0, "R3");
        cycle(8'h00, 1'b1, "R6");
        check(detect_o, 1'b0, "R6");
        for (int k = 0; k < 127; k++) cycle(8'h00, 1'b0, "R6");
        check(detect_o, 1'b1, "R6");

        // R5: flag ignores a bus change until the next edge, then R1 clears it
        sample_i = 8'hFF;
        #1;
        check(detect_o, 1'b1, "R5");
        @(posedge clk);
        cnt = 0;
        @(negedge clk);
        check(detect_o, 1'b0, "R1");

        // R1: nonzero right after reset-free restart, short run stays low
        for (int k = 0; k < 126; k++) cycle(8'h00, 1'b0, "R3");
        cycle(8'h05, 1'b0, "R1");
        cycle(8'h00, 1'b0, "R1");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule